// File: doc/BRIEF.md
# Cascaded Secondary Interrupt Controller

This block collects a bank of peripheral interrupt lines and reduces them to one summary request for a parent interrupt controller. Every line is first brought into the local clock domain by a synchroniser chain. Software then chooses, line by line, whether the line is level-sensitive or edge-triggered and which sense counts as active. An edge-triggered line records each qualifying edge in a pending latch. The latch holds until software acknowledges it. A level-sensitive line is pending only while its input is in the active state.

Software uses a small word-addressed register bus. The enable mask is never written directly. Bits are turned on through a write-one-to-set alias and turned off through a write-one-to-clear alias, and the mask itself can be read back. A status word shows the pending lines that are also enabled. A helper register, mirrored on dedicated output ports, gives the lowest-numbered line in that status word. The handler on the processor side can therefore service lines in ascending order without scanning the bits itself.

Top module: `irq_cascade_ctrl`

## Requirements
- R1: After reset the enable, mode, polarity and status words all read 0, the lowest-pending word reads 0, and `parent_irq` is low.
- R2: A write to word address 1 (enable-set) sets exactly those enable bits that are 1 in the write data. All other enable bits keep their value.
- R3: A write to word address 2 (enable-clear) clears exactly those enable bits that are 1 in the write data. All other enable bits keep their value.
- R4: Word address 0 returns the enable mask, bit n for line n. A write to address 0 has no effect.
- R5: Mode word (address 3) bit n = 0 makes line n level-sensitive. Polarity word (address 4) bit n = 0 makes it active-high, and bit n = 1 makes it active-low. A level line is pending while its synchronised input is in the active state.
- R6: Mode bit n = 1 makes line n edge-triggered. Polarity 0 selects rising edges and polarity 1 selects falling edges. A qualifying edge sets the pending latch, and the latch stays set after the input returns to its idle state.
- R7: Writing a 1 to bit n of the acknowledge word (address 5) clears the edge latch of line n. An acknowledge to a level line leaves its pending state unchanged.
- R8: If an acknowledge and a new qualifying edge on the same line fall in the same cycle, the line stays pending.
- R9: The status word (address 6) equals pending AND enable. Edges on a disabled edge line are still latched, and they appear in status once the line is enabled.
- R10: `parent_irq` is high exactly when the status word is nonzero.
- R11: The lowest-pending word (address 7) has bit 31 = valid and bits [4:0] = the index of the lowest set status bit. The same values appear on `low_valid` and `low_idx`. When status is zero, the word is 0.
- R12: An input change reaches a level line's status two clock edges after it is sampled. An edge line's latch sets one edge after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_irq | input | NUM_SRC | Asynchronous peripheral interrupt lines |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` (combinational) |
| parent_irq | output | 1 | Summary request to the parent controller |
| low_idx | output | IDX_W | Index of the lowest pending enabled line |
| low_valid | output | 1 | Some enabled line is pending |

## Verification
The bench builds the block with its default parameters: 32 lines, a 32-bit data word, a 3-bit address and a two-stage synchroniser. This reaches the top line index 31 and the valid bit at position 31 in the lowest-pending word. The fixed two-stage depth lets the behavioural model predict the exact cycle in which a level or edge appears. That precision is what allows the bench to land an acknowledge on the same cycle as a new edge. A random phase then mixes mode, polarity, enable and acknowledge writes with toggling inputs, and the model is compared on every clock.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   localparam int unsigned REG_ENABLE = 0;
   localparam int unsigned REG_EN_SET = 1;
   localparam int unsigned REG_EN_CLR = 2;
   localparam int unsigned REG_MODE   = 3;
   localparam int unsigned REG_POL    = 4;
   localparam int unsigned REG_ACK    = 5;
   localparam int unsigned REG_STATUS = 6;
   localparam int unsigned REG_LOWEST = 7;
   localparam int unsigned MIN_ADDR_W = 3;
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
   parameter int unsigned WIDTH  = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [STAGES-1:0][WIDTH-1:0] chain;

   always_ff @(posedge clk) begin
      if (rst) begin
         chain <= '0;
      end else begin
         chain[0] <= d;
         for (int s = 1; s < STAGES; s++) begin
            chain[s] <= chain[s-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/irqc_line.sv
module irqc_line (
   input  logic clk,
   input  logic rst,
   input  logic lvl,
   input  logic mode_edge,
   input  logic pol_low,
   input  logic ack,
   output logic pending
);
   logic prev_q;
   logic latch_q;
   logic edge_hit;

   always_ff @(posedge clk) begin
      if (rst) prev_q <= 1'b0;
      else     prev_q <= lvl;
   end

   // qualifying edge, sense chosen by polarity
   assign edge_hit = pol_low ? (prev_q & ~lvl) : (~prev_q & lvl);

   // a new edge has priority over an acknowledge in the same cycle
   always_ff @(posedge clk) begin
      if (rst)            latch_q <= 1'b0;
      else if (!mode_edge) latch_q <= 1'b0;
      else                latch_q <= (latch_q & ~ack) | edge_hit;
   end

   assign pending = mode_edge ? latch_q : (lvl ^ pol_low);
endmodule

// File: rtl/irqc_lowest.sv
module irqc_lowest #(
   parameter int unsigned N     = 32,
   parameter int unsigned IDX_W = 5
) (
   input  logic [N-1:0]     req,
   output logic [IDX_W-1:0] idx,
   output logic             valid
);
   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = IDX_W'(i);
      end
   end

   assign valid = |req;
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
   import irqc_pkg::*;
#(
   parameter int unsigned NUM_SRC = 32,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned ADDR_W  = 3,
   parameter int unsigned IDX_W   = 5
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               bus_wr,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [DATA_W-1:0]  bus_wdata,
   input  logic [NUM_SRC-1:0] status,
   input  logic [IDX_W-1:0]   low_idx,
   input  logic               low_valid,
   output logic [NUM_SRC-1:0] en_q,
   output logic [NUM_SRC-1:0] mode_q,
   output logic [NUM_SRC-1:0] pol_q,
   output logic [NUM_SRC-1:0] ack,
   output logic [DATA_W-1:0]  bus_rdata
);
   logic [NUM_SRC-1:0] wbits;
   logic wr_set, wr_clr, wr_mode, wr_pol, wr_ack;

   assign wbits   = bus_wdata[NUM_SRC-1:0];
   assign wr_set  = bus_wr && (bus_addr == ADDR_W'(REG_EN_SET));
   assign wr_clr  = bus_wr && (bus_addr == ADDR_W'(REG_EN_CLR));
   assign wr_mode = bus_wr && (bus_addr == ADDR_W'(REG_MODE));
   assign wr_pol  = bus_wr && (bus_addr == ADDR_W'(REG_POL));
   assign wr_ack  = bus_wr && (bus_addr == ADDR_W'(REG_ACK));

   always_ff @(posedge clk) begin
      if (rst) begin
         en_q   <= '0;
         mode_q <= '0;
         pol_q  <= '0;
      end else begin
         if (wr_set)  en_q   <= en_q | wbits;
         if (wr_clr)  en_q   <= en_q & ~wbits;
         if (wr_mode) mode_q <= wbits;
         if (wr_pol)  pol_q  <= wbits;
      end
   end

   assign ack = wr_ack ? wbits : '0;

   always_comb begin
      bus_rdata = '0;
      unique case (bus_addr)
         ADDR_W'(REG_ENABLE): bus_rdata[NUM_SRC-1:0] = en_q;
         ADDR_W'(REG_MODE):   bus_rdata[NUM_SRC-1:0] = mode_q;
         ADDR_W'(REG_POL):    bus_rdata[NUM_SRC-1:0] = pol_q;
         ADDR_W'(REG_STATUS): bus_rdata[NUM_SRC-1:0] = status;
         ADDR_W'(REG_LOWEST): begin
            bus_rdata[DATA_W-1]  = low_valid;
            bus_rdata[IDX_W-1:0] = low_idx;
         end
         default: bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/irq_cascade_ctrl.sv
module irq_cascade_ctrl
   import irqc_pkg::*;
#(
   parameter int unsigned NUM_SRC     = 32,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned ADDR_W      = 3,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned IDX_W      = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [NUM_SRC-1:0] src_irq,
   input  logic               bus_wr,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   output logic               parent_irq,
   output logic [IDX_W-1:0]   low_idx,
   output logic               low_valid
);
   initial begin
      if (NUM_SRC < 1 || NUM_SRC > DATA_W)
         $error("NUM_SRC must lie in 1..DATA_W");
      if (IDX_W >= DATA_W)
         $error("index field collides with the valid bit");
      if (ADDR_W < MIN_ADDR_W)
         $error("ADDR_W too small for the register map");
      if (SYNC_STAGES < 2)
         $error("SYNC_STAGES must be at least 2");
   end

   logic [NUM_SRC-1:0] lvl;
   logic [NUM_SRC-1:0] en_q, mode_q, pol_q, ack;
   logic [NUM_SRC-1:0] pend;
   logic [NUM_SRC-1:0] status;

   irqc_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst(rst), .d(src_irq), .q(lvl)
   );

   generate
      for (genvar n = 0; n < NUM_SRC; n++) begin : g_line
         irqc_line u_line (
            .clk(clk), .rst(rst), .lvl(lvl[n]),
            .mode_edge(mode_q[n]), .pol_low(pol_q[n]),
            .ack(ack[n]), .pending(pend[n])
         );
      end
   endgenerate

   assign status     = pend & en_q;
   assign parent_irq = |status;

   irqc_lowest #(.N(NUM_SRC), .IDX_W(IDX_W)) u_lowest (
      .req(status), .idx(low_idx), .valid(low_valid)
   );

   irqc_regs #(
      .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W)
   ) u_regs (
      .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .status(status), .low_idx(low_idx),
      .low_valid(low_valid), .en_q(en_q), .mode_q(mode_q), .pol_q(pol_q),
      .ack(ack), .bus_rdata(bus_rdata)
   );
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
   import irqc_pkg::*;
#(
   parameter int unsigned NUM_SRC = 32,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned ADDR_W  = 3,
   parameter int unsigned IDX_W   = 5
) (
   input logic               clk,
   input logic               rst,
   input logic               bus_wr,
   input logic [ADDR_W-1:0]  bus_addr,
   input logic [DATA_W-1:0]  bus_wdata,
   input logic [NUM_SRC-1:0] en_q,
   input logic [NUM_SRC-1:0] status,
   input logic               parent_irq,
   input logic [IDX_W-1:0]   low_idx,
   input logic               low_valid
);
   logic [NUM_SRC-1:0] wbits;
   logic [NUM_SRC-1:0] below;
   logic set_wr, clr_wr, en_wr;

   assign wbits  = bus_wdata[NUM_SRC-1:0];
   assign below  = (NUM_SRC'(1) << low_idx) - NUM_SRC'(1);
   assign set_wr = bus_wr && (bus_addr == ADDR_W'(REG_EN_SET));
   assign clr_wr = bus_wr && (bus_addr == ADDR_W'(REG_EN_CLR));
   assign en_wr  = bus_wr && (bus_addr == ADDR_W'(REG_ENABLE));

   a_r2_set_ones: assert property (@(posedge clk) disable iff (rst)
      set_wr |=> ((en_q & $past(wbits)) == $past(wbits)));
   a_r2_set_keeps: assert property (@(posedge clk) disable iff (rst)
      set_wr |=> ((en_q & ~$past(wbits)) == ($past(en_q) & ~$past(wbits))));
   a_r3_clr_ones: assert property (@(posedge clk) disable iff (rst)
      clr_wr |=> ((en_q & $past(wbits)) == '0));
   a_r3_clr_keeps: assert property (@(posedge clk) disable iff (rst)
      clr_wr |=> ((en_q & ~$past(wbits)) == ($past(en_q) & ~$past(wbits))));
   a_r4_enable_ro: assert property (@(posedge clk) disable iff (rst)
      en_wr |=> (en_q == $past(en_q)));
   a_r10_summary_matches_valid: assert property (@(posedge clk) disable iff (rst)
      parent_irq == low_valid);
   a_r11_lowest_is_set: assert property (@(posedge clk) disable iff (rst)
      low_valid |-> status[low_idx]);
   a_r11_none_below: assert property (@(posedge clk) disable iff (rst)
      low_valid |-> ((status & below) == '0));
endmodule

bind irq_cascade_ctrl irqc_checker #(
   .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W)
) u_chk (
   .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
   .bus_wdata(bus_wdata), .en_q(en_q), .status(status),
   .parent_irq(parent_irq), .low_idx(low_idx), .low_valid(low_valid)
);

// File: tb/tb_irq_cascade_ctrl.sv
`timescale 1ns/1ps
module tb_irq_cascade_ctrl;
   localparam int N = 32;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [N-1:0] src_irq = '0;
   logic        bus_wr = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        parent_irq;
   logic [4:0]  low_idx;
   logic        low_valid;

   int checks = 0;
   int errors = 0;

   irq_cascade_ctrl dut (
      .clk(clk), .rst(rst), .src_irq(src_irq), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .parent_irq(parent_irq), .low_idx(low_idx), .low_valid(low_valid)
   );

   always #5 clk = ~clk;

   // behavioural reference: input delay history and software-visible state
   logic [N-1:0] m_hist [3];
   logic [N-1:0] m_en, m_mode, m_pol, m_latch;

   function automatic logic [N-1:0] m_status();
      logic [N-1:0] st;
      for (int i = 0; i < N; i++) begin
         logic p;
         p = m_mode[i] ? m_latch[i] : (m_hist[1][i] ^ m_pol[i]);
         st[i] = p & m_en[i];
      end
      return st;
   endfunction

   always @(posedge clk) begin
      if (rst) begin
         for (int k = 0; k < 3; k++) m_hist[k] = '0;
         m_en = '0; m_mode = '0; m_pol = '0; m_latch = '0;
      end else begin
         logic [N-1:0] nl;
         for (int i = 0; i < N; i++) begin
            logic cur, old, hit, ackb;
            cur  = m_hist[1][i];
            old  = m_hist[2][i];
            hit  = m_pol[i] ? (old && !cur) : (!old && cur);
            ackb = bus_wr && bus_addr == 3'd5 && bus_wdata[i];
            if (!m_mode[i]) nl[i] = 1'b0;
            else if (hit)   nl[i] = 1'b1;
            else if (ackb)  nl[i] = 1'b0;
            else            nl[i] = m_latch[i];
         end
         m_latch = nl;
         m_hist[2] = m_hist[1];
         m_hist[1] = m_hist[0];
         m_hist[0] = src_irq;
         if (bus_wr) begin
            case (bus_addr)
               3'd1: m_en   = m_en | bus_wdata;
               3'd2: m_en   = m_en & ~bus_wdata;
               3'd3: m_mode = bus_wdata;
               3'd4: m_pol  = bus_wdata;
               default: ;
            endcase
         end
      end
   end

   // per-cycle comparison against the reference
   always @(posedge clk) begin
      #2;
      if (!rst) begin
         logic [N-1:0] st;
         logic         ev;
         logic [4:0]   ei;
         st = m_status();
         ev = |st;
         ei = '0;
         for (int i = N - 1; i >= 0; i--) if (st[i]) ei = 5'(i);
         checks++;
         if (parent_irq !== ev) begin
            errors++;
            $display("FAIL R10 parent_irq actual %0b expected %0b", parent_irq, ev);
         end
         checks++;
         if (low_valid !== ev || (ev && low_idx !== ei)) begin
            errors++;
            $display("FAIL R11 low valid/idx actual %0b/%0d expected %0b/%0d",
                     low_valid, low_idx, ev, ei);
         end
      end
   end

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
      @(negedge clk);
      bus_addr = a;
      #1;
      checks++;
      if (bus_rdata !== exp) begin
         errors++;
         $display("FAIL %s addr %0d actual %h expected %h", tag, a, bus_rdata, exp);
      end
   endtask

   task automatic chk_bit(input logic act, input logic exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0b expected %0b", tag, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #(200000 * 10);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R1 reset state
      rd(3'd0, 32'h0, "R1 enable");
      rd(3'd3, 32'h0, "R1 mode");
      rd(3'd4, 32'h0, "R1 polarity");
      rd(3'd6, 32'h0, "R1 status");
      rd(3'd7, 32'h0, "R1 lowest");
      chk_bit(parent_irq, 1'b0, "R1 parent_irq");
      // R2 set alias
      wr(3'd1, 32'h0000_00F0);
      rd(3'd0, 32'h0000_00F0, "R2 set first");
      wr(3'd1, 32'h0000_0003);
      rd(3'd0, 32'h0000_00F3, "R2 set keeps");
      // R3 clear alias
      wr(3'd2, 32'h0000_0030);
      rd(3'd0, 32'h0000_00C3, "R3 clear some");
      wr(3'd2, 32'hFFFF_FFFF);
      rd(3'd0, 32'h0, "R3 clear all");
      // R4 enable address is read-only
      wr(3'd0, 32'h0000_FFFF);
      rd(3'd0, 32'h0, "R4 write ignored");
      // R5 level lines, both senses
      wr(3'd1, 32'h0000_000C);
      wr(3'd4, 32'h0000_0008);
      rd(3'd6, 32'h0000_0008, "R5 active-low idle input");
      // R12 two-edge latency on a level line
      @(negedge clk); src_irq[2] = 1'b1;
      rd(3'd6, 32'h0000_0008, "R12 after one edge");
      rd(3'd6, 32'h0000_000C, "R12 after two edges");
      @(negedge clk); src_irq[3] = 1'b1;
      idle(3);
      rd(3'd6, 32'h0000_0004, "R5 active-low line deasserted");
      chk_bit(parent_irq, 1'b1, "R10 summary high");
      rd(3'd7, 32'h8000_0002, "R11 lowest is 2");
      // R7 acknowledge on a level line has no lasting effect
      wr(3'd5, 32'h0000_0004);
      rd(3'd6, 32'h0000_0004, "R7 level ack");
      // R6 edge lines: 5 rising, 6 falling
      wr(3'd3, 32'h0000_0060);
      wr(3'd4, 32'h0000_0048);
      wr(3'd1, 32'h0000_0060);
      rd(3'd6, 32'h0000_0004, "R6 no edge yet");
      @(negedge clk); src_irq[5] = 1'b1;
      @(negedge clk); src_irq[5] = 1'b0;
      idle(5);
      rd(3'd6, 32'h0000_0024, "R6 rising latched after pulse");
      @(negedge clk); src_irq[6] = 1'b1;
      idle(4);
      rd(3'd6, 32'h0000_0024, "R6 rise ignored on falling line");
      @(negedge clk); src_irq[6] = 1'b0;
      idle(4);
      rd(3'd6, 32'h0000_0064, "R6 falling latched");
      @(negedge clk); src_irq[2] = 1'b0;
      idle(4);
      rd(3'd7, 32'h8000_0005, "R11 lowest is 5");
      // R7 acknowledge clears an edge latch
      wr(3'd5, 32'h0000_0020);
      rd(3'd6, 32'h0000_0040, "R7 edge ack");
      // R8 acknowledge and new edge in the same cycle
      @(negedge clk); src_irq[6] = 1'b1;
      idle(4);
      @(negedge clk); src_irq[6] = 1'b0;
      @(negedge clk);
      @(negedge clk); bus_wr = 1'b1; bus_addr = 3'd5; bus_wdata = 32'h40;
      @(negedge clk); bus_wr = 1'b0; bus_wdata = '0;
      rd(3'd6, 32'h0000_0040, "R8 edge wins");
      wr(3'd5, 32'h0000_0040);
      rd(3'd6, 32'h0, "R8 later ack clears");
      chk_bit(parent_irq, 1'b0, "R10 summary low");
      rd(3'd7, 32'h0, "R11 lowest empty");
      // R9 disabled edge line still latches
      wr(3'd3, 32'h0000_00E0);
      @(negedge clk); src_irq[7] = 1'b1;
      @(negedge clk); src_irq[7] = 1'b0;
      idle(4);
      rd(3'd6, 32'h0, "R9 masked");
      chk_bit(parent_irq, 1'b0, "R9 summary masked");
      wr(3'd1, 32'h0000_0080);
      rd(3'd6, 32'h0000_0080, "R9 appears on enable");
      // R11 top index
      wr(3'd1, 32'h8000_0000);
      @(negedge clk); src_irq[31] = 1'b1;
      idle(3);
      rd(3'd7, 32'h8000_0007, "R11 lowest still 7");
      wr(3'd5, 32'h0000_0080);
      rd(3'd7, 32'h8000_001F, "R11 lowest is 31");
      // random mix checked every clock by the reference
      for (int c = 0; c < 2000; c++) begin
         @(negedge clk);
         src_irq = src_irq ^ ($urandom() & $urandom() & $urandom());
         if (($urandom() % 4) == 0) begin
            bus_wr = 1'b1;
            bus_addr = 3'($urandom() % 6);
            bus_wdata = $urandom();
         end else begin
            bus_wr = 1'b0;
         end
      end
      @(negedge clk); bus_wr = 1'b0;
      idle(4);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule